// File: doc/BRIEF.md
# Dual-Processor Mailbox and Semaphore Registers

This block is a small register file that a main CPU and a coprocessor share. It gives them a 32-bit semaphore word, which they update through separate set and clear ports, and a one-word mailbox in each direction. The inbox carries words from the coprocessor to the CPU. The outbox carries words from the CPU to the coprocessor.

Every mailbox word holds a valid tag. Hardware raises the tag when the sending side writes the word and drops it when the receiving side reads it. Two enable bits inside the same word decide whether the receiver is interrupted while the mailbox is full and whether the sender is interrupted while it is empty.

Access is through a single-cycle register bus. Alongside each access, a one-bit source input tells the block which processor issued it. Read data appears one cycle after the read. The two interrupt lines are levels that follow the current enable and tag bits.

Top module: `dualcore_mbx_sema`

## Requirements
- R1: After reset the semaphore word and both mailbox words are zero. The read data bus is zero and both interrupt outputs are low.
- R2: A write to byte offset 0x04 sets every semaphore bit whose write-data bit is 1 and leaves the others unchanged. Reading offset 0x00 returns the semaphore word.
- R3: A write to offset 0x08 clears every semaphore bit whose write-data bit is 1. Reads of offsets 0x04 and 0x08 return zero.
- R4: The read data output presents the addressed word in the cycle after a read access. It is zero in any cycle that follows no read.
- R5: The inbox is at offset 0x10. A write from the coprocessor (acc_src=1) sets its tag at bit 29. A read from the CPU (acc_src=0) returns the tag still set and then clears it.
- R6: The outbox is at offset 0x20. A write from the CPU (acc_src=0) sets its tag at bit 29. A read from the coprocessor (acc_src=1) returns the tag still set and then clears it.
- R7: A mailbox write stores bits 31:30 and 27:0 of the write data. Bit 29 is the hardware tag and bit 28 always reads 0. A write by the receiving side leaves the tag unchanged, and so does a read by the sending side.
- R8: irq_cpu is high exactly when the inbox has bit 31 and its tag set, or the outbox has bit 30 set and its tag clear. It changes at the same clock edge as the bits it depends on.
- R9: irq_cop is high exactly when the outbox has bit 31 and its tag set, or the inbox has bit 30 set and its tag clear. It changes at the same clock edge as the bits it depends on.
- R10: Reads of offsets 0x0C, 0x14, 0x18, 0x1C and any other unmapped offset return zero. Writes to those offsets and to offset 0x00 change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Access valid this cycle |
| acc_wr | input | 1 | 1 for a write, 0 for a read |
| acc_addr | input | ADDR_W | Byte offset of the access |
| acc_wdata | input | 32 | Write data |
| acc_src | input | 1 | Issuing processor: 0 is the CPU, 1 is the coprocessor |
| acc_rdata | output | 32 | Read data, valid in the cycle after a read |
| irq_cpu | output | 1 | Level interrupt to the CPU |
| irq_cop | output | 1 | Level interrupt to the coprocessor |

## Verification
- A write updates the semaphore word or a mailbox at the clock edge that ends the access cycle.
- A read's data is registered at that same edge, before the tag clear it causes takes effect. The reader therefore sees the tag set, and the cleared tag shows only on a later read.
- The interrupt levels come straight from the stored bits, so they change at that same edge.
- The bench drives every access on a falling edge and samples the read data and both interrupts on the next falling edge. Its model advances one access per cycle, so each result is compared in the cycle it is due.

// File: rtl/mbxs_pkg.sv
package mbxs_pkg;

  localparam int WORD_W = 32;

  // Register byte offsets; the processors' software depends on these.
  localparam logic [7:0] OFS_STATUS = 8'h00;
  localparam logic [7:0] OFS_SET    = 8'h04;
  localparam logic [7:0] OFS_CLEAR  = 8'h08;
  localparam logic [7:0] OFS_INBOX  = 8'h10;
  localparam logic [7:0] OFS_OUTBOX = 8'h20;

  // Mailbox word field positions.
  localparam int BIT_EN_FULL  = 31;
  localparam int BIT_EN_EMPTY = 30;
  localparam int BIT_TAG      = 29;
  localparam int BIT_RSVD     = 28;

  // Bits of the write data that a mailbox keeps.
  localparam logic [WORD_W-1:0] KEEP_MASK = 32'hCFFF_FFFF;

  typedef enum logic {
    SRC_CPU = 1'b0,
    SRC_COP = 1'b1
  } src_e;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_SET,
    SEL_CLEAR,
    SEL_INBOX,
    SEL_OUTBOX
  } regsel_e;

endpackage

// File: rtl/mbxs_decode.sv
module mbxs_decode
  import mbxs_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output regsel_e           sel
);

  always_comb begin
    if (addr == OFS_STATUS[ADDR_W-1:0])       sel = SEL_STATUS;
    else if (addr == OFS_SET[ADDR_W-1:0])     sel = SEL_SET;
    else if (addr == OFS_CLEAR[ADDR_W-1:0])   sel = SEL_CLEAR;
    else if (addr == OFS_INBOX[ADDR_W-1:0])   sel = SEL_INBOX;
    else if (addr == OFS_OUTBOX[ADDR_W-1:0])  sel = SEL_OUTBOX;
    else                                      sel = SEL_NONE;
  end

endmodule

// File: rtl/mbxs_sema_bank.sv
module mbxs_sema_bank #(
  parameter int SEMA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic [SEMA_W-1:0] bits,
  output logic [SEMA_W-1:0] sema_q
);

  logic [SEMA_W-1:0] set_m;
  logic [SEMA_W-1:0] clr_m;
  logic [SEMA_W-1:0] sema_d;
  logic              sema_ce;

  // Set is applied after clear so that a set wins a collision.
  always_comb begin
    set_m   = set_we ? bits : '0;
    clr_m   = clr_we ? bits : '0;
    sema_d  = (sema_q & ~clr_m) | set_m;
    sema_ce = set_we | clr_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sema_q <= '0;
    else if (sema_ce) sema_q <= sema_d;
  end

endmodule

// File: rtl/mbxs_slot.sv
module mbxs_slot
  import mbxs_pkg::*;
#(
  parameter src_e SENDER = SRC_CPU
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic              rd_hit,
  input  logic              src,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] word,
  output logic              full_irq,
  output logic              empty_irq
);

  logic [WORD_W-1:0] fields_q;
  logic [WORD_W-1:0] fields_d;
  logic              tag_q;
  logic              tag_d;
  logic              tag_ce;
  logic              from_sender;

  always_comb begin
    from_sender = (src == SENDER);
    fields_d    = wdata & KEEP_MASK;
    tag_d       = tag_q;
    if (wr_hit && from_sender)       tag_d = 1'b1;
    else if (rd_hit && !from_sender) tag_d = 1'b0;
    tag_ce      = wr_hit | rd_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fields_q <= '0;
    else if (wr_hit) fields_q <= fields_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tag_q <= 1'b0;
    else if (tag_ce) tag_q <= tag_d;
  end

  always_comb begin
    word          = fields_q;
    word[BIT_TAG] = tag_q;
    full_irq      = fields_q[BIT_EN_FULL] & tag_q;
    empty_irq     = fields_q[BIT_EN_EMPTY] & ~tag_q;
  end

endmodule

// File: rtl/mbxs_rd_port.sv
module mbxs_rd_port
  import mbxs_pkg::*;
#(
  parameter int SEMA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  regsel_e           sel,
  input  logic [SEMA_W-1:0] sema,
  input  logic [WORD_W-1:0] inbox,
  input  logic [WORD_W-1:0] outbox,
  output logic [WORD_W-1:0] rdata_q
);

  logic [WORD_W-1:0] rdata_d;

  always_comb begin
    rdata_d = '0;
    if (rd_en) begin
      unique case (sel)
        SEL_STATUS: rdata_d = WORD_W'(sema);
        SEL_INBOX:  rdata_d = inbox;
        SEL_OUTBOX: rdata_d = outbox;
        default:    rdata_d = '0;
      endcase
    end
  end

  // Loaded every cycle: the bus returns zero when nothing was read.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

endmodule

// File: rtl/dualcore_mbx_sema.sv
module dualcore_mbx_sema
  import mbxs_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int SEMA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [31:0]       acc_wdata,
  input  logic              acc_src,
  output logic [31:0]       acc_rdata,
  output logic              irq_cpu,
  output logic              irq_cop
);

  localparam int NUM_BOX = 2;
  localparam int IDX_IN  = 0;
  localparam int IDX_OUT = 1;

  regsel_e           sel;
  logic              wr_go;
  logic              rd_go;
  logic [SEMA_W-1:0] sema_q;
  logic [WORD_W-1:0] mb_word  [NUM_BOX];
  logic              mb_full  [NUM_BOX];
  logic              mb_empty [NUM_BOX];
  logic [WORD_W-1:0] inbox_w;
  logic [WORD_W-1:0] outbox_w;

  assign wr_go = acc_en & acc_wr;
  assign rd_go = acc_en & ~acc_wr;

  mbxs_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (acc_addr),
    .sel  (sel)
  );

  mbxs_sema_bank #(.SEMA_W(SEMA_W)) u_sema (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_we (wr_go && sel == SEL_SET),
    .clr_we (wr_go && sel == SEL_CLEAR),
    .bits   (acc_wdata[SEMA_W-1:0]),
    .sema_q (sema_q)
  );

  for (genvar i = 0; i < NUM_BOX; i++) begin : g_box
    localparam src_e    SND = (i == IDX_IN) ? SRC_COP : SRC_CPU;
    localparam regsel_e MYS = (i == IDX_IN) ? SEL_INBOX : SEL_OUTBOX;
    mbxs_slot #(.SENDER(SND)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_hit    (wr_go && sel == MYS),
      .rd_hit    (rd_go && sel == MYS),
      .src       (acc_src),
      .wdata     (acc_wdata),
      .word      (mb_word[i]),
      .full_irq  (mb_full[i]),
      .empty_irq (mb_empty[i])
    );
  end

  assign inbox_w  = mb_word[IDX_IN];
  assign outbox_w = mb_word[IDX_OUT];

  // Full goes to the receiver, empty to the sender.
  assign irq_cpu = mb_full[IDX_IN]  | mb_empty[IDX_OUT];
  assign irq_cop = mb_full[IDX_OUT] | mb_empty[IDX_IN];

  mbxs_rd_port #(.SEMA_W(SEMA_W)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_go),
    .sel     (sel),
    .sema    (sema_q),
    .inbox   (inbox_w),
    .outbox  (outbox_w),
    .rdata_q (acc_rdata)
  );

endmodule

// File: rtl/mbxs_checker.sv
module mbxs_checker
  import mbxs_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int SEMA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_en,
  input logic              acc_wr,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [31:0]       acc_wdata,
  input logic              acc_src,
  input logic [31:0]       acc_rdata,
  input logic              irq_cpu,
  input logic              irq_cop,
  input logic [SEMA_W-1:0] sema_q,
  input logic [31:0]       inbox_w,
  input logic [31:0]       outbox_w
);

  logic wr_set, wr_clr, wr_in, wr_out, rd_in, rd_out, rd_any, rd_rsvd;

  always_comb begin
    wr_set  = acc_en && acc_wr && acc_addr == OFS_SET[ADDR_W-1:0];
    wr_clr  = acc_en && acc_wr && acc_addr == OFS_CLEAR[ADDR_W-1:0];
    wr_in   = acc_en && acc_wr && acc_addr == OFS_INBOX[ADDR_W-1:0];
    wr_out  = acc_en && acc_wr && acc_addr == OFS_OUTBOX[ADDR_W-1:0];
    rd_any  = acc_en && !acc_wr;
    rd_in   = rd_any && acc_addr == OFS_INBOX[ADDR_W-1:0];
    rd_out  = rd_any && acc_addr == OFS_OUTBOX[ADDR_W-1:0];
    rd_rsvd = rd_any && (acc_addr == ADDR_W'(8'h0C) || acc_addr == ADDR_W'(8'h14) ||
                         acc_addr == ADDR_W'(8'h18) || acc_addr == ADDR_W'(8'h1C));
  end

  AST_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((sema_q & $past(acc_wdata[SEMA_W-1:0])) == $past(acc_wdata[SEMA_W-1:0]))); // R2
  AST_CLR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((sema_q & $past(acc_wdata[SEMA_W-1:0])) == '0)); // R3
  AST_SEMA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_set || wr_clr) |=> $stable(sema_q)); // R10
  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_any |=> (acc_rdata == '0)); // R4
  AST_IN_TAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_in && acc_src == SRC_COP) |=> inbox_w[BIT_TAG]); // R5
  AST_IN_TAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_in && acc_src == SRC_CPU) |=> !inbox_w[BIT_TAG]); // R5
  AST_IN_TAG_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_in && inbox_w[BIT_TAG]) |=> acc_rdata[BIT_TAG]); // R5
  AST_OUT_TAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_out && acc_src == SRC_CPU) |=> outbox_w[BIT_TAG]); // R6
  AST_OUT_TAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_out && acc_src == SRC_COP) |=> !outbox_w[BIT_TAG]); // R6
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !inbox_w[BIT_RSVD] && !outbox_w[BIT_RSVD]); // R7
  AST_IRQ_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    irq_cpu == ((inbox_w[BIT_EN_FULL] && inbox_w[BIT_TAG]) ||
                (outbox_w[BIT_EN_EMPTY] && !outbox_w[BIT_TAG]))); // R8
  AST_IRQ_COP: assert property (@(posedge clk) disable iff (!rst_n)
    irq_cop == ((outbox_w[BIT_EN_FULL] && outbox_w[BIT_TAG]) ||
                (inbox_w[BIT_EN_EMPTY] && !inbox_w[BIT_TAG]))); // R9
  AST_RSVD_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rsvd |=> (acc_rdata == '0)); // R10

endmodule

bind dualcore_mbx_sema mbxs_checker #(.ADDR_W(ADDR_W), .SEMA_W(SEMA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_en    (acc_en),
  .acc_wr    (acc_wr),
  .acc_addr  (acc_addr),
  .acc_wdata (acc_wdata),
  .acc_src   (acc_src),
  .acc_rdata (acc_rdata),
  .irq_cpu   (irq_cpu),
  .irq_cop   (irq_cop),
  .sema_q    (sema_q),
  .inbox_w   (inbox_w),
  .outbox_w  (outbox_w)
);

// File: tb/dualcore_mbx_sema_test.sv
`timescale 1ns/1ps
module dualcore_mbx_sema_test;

  logic        clk;
  logic        rst_n;
  logic        acc_en;
  logic        acc_wr;
  logic [5:0]  acc_addr;
  logic [31:0] acc_wdata;
  logic        acc_src;
  logic [31:0] acc_rdata;
  logic        irq_cpu;
  logic        irq_cop;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // Behavioural model state
  logic [31:0] m_sema, m_in_f, m_out_f;
  bit          m_in_t, m_out_t;

  dualcore_mbx_sema uut (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_src(acc_src),
    .acc_rdata(acc_rdata), .irq_cpu(irq_cpu), .irq_cop(irq_cop)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h00:   return m_sema;
      8'h10:   return m_in_f  | (32'(m_in_t)  << 29);
      8'h20:   return m_out_f | (32'(m_out_t) << 29);
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One bus cycle: drive on a falling edge, compare on the next one.
  task automatic step(input bit en, input bit wr, input logic [7:0] a,
                      input bit src, input logic [31:0] wd, input string req);
    logic [31:0] exp_rd;
    bit e_cpu, e_cop;
    @(negedge clk);
    acc_en = en; acc_wr = wr; acc_addr = a[5:0]; acc_src = src; acc_wdata = wd;
    exp_rd = (en && !wr) ? m_read(a) : 32'h0;
    if (en && wr) begin
      case (a)
        8'h04: m_sema = m_sema | wd;
        8'h08: m_sema = m_sema & ~wd;
        8'h10: begin m_in_f  = wd & 32'hCFFF_FFFF; if (src)  m_in_t  = 1; end
        8'h20: begin m_out_f = wd & 32'hCFFF_FFFF; if (!src) m_out_t = 1; end
        default: ;
      endcase
    end else if (en) begin
      if (a == 8'h10 && !src) m_in_t  = 0;
      if (a == 8'h20 &&  src) m_out_t = 0;
    end
    e_cpu = (m_in_f[31] && m_in_t) || (m_out_f[30] && !m_out_t);
    e_cop = (m_out_f[31] && m_out_t) || (m_in_f[30] && !m_in_t);
    @(negedge clk);
    acc_en = 1'b0;
    check(req, "rdata",   acc_rdata,     exp_rd);
    check(req, "irq_cpu", 32'(irq_cpu),  32'(e_cpu));
    check(req, "irq_cop", 32'(irq_cop),  32'(e_cop));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; acc_en = 0; acc_wr = 0; acc_addr = '0; acc_src = 0; acc_wdata = '0;
    m_sema = '0; m_in_f = '0; m_out_f = '0; m_in_t = 0; m_out_t = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1", "rdata",   acc_rdata,     32'h0);
    check("R1", "irq_cpu", 32'(irq_cpu),  32'h0);
    check("R1", "irq_cop", 32'(irq_cop),  32'h0);
    step(1, 0, 8'h00, 0, 0, "R1");
    step(1, 0, 8'h10, 0, 0, "R1");
    step(1, 0, 8'h20, 1, 0, "R1");
    // R2 set register
    step(1, 1, 8'h04, 0, 32'hA5A5_0001, "R2");
    step(1, 0, 8'h00, 1, 0, "R2");
    step(1, 1, 8'h04, 1, 32'h0000_0100, "R2");
    step(1, 0, 8'h00, 0, 0, "R2");
    // R10 status write ignored
    step(1, 1, 8'h00, 0, 32'hFFFF_FFFF, "R10");
    step(1, 0, 8'h00, 0, 0, "R10");
    // R3 clear register and zero reads
    step(1, 1, 8'h08, 1, 32'h8001_0001, "R3");
    step(1, 0, 8'h00, 0, 0, "R3");
    step(1, 0, 8'h04, 0, 0, "R3");
    step(1, 0, 8'h08, 1, 0, "R3");
    // R4 idle cycle returns zero
    step(0, 0, 8'h00, 0, 0, "R4");
    // R5 R7 R8 inbox with full enable
    step(1, 1, 8'h10, 1, 32'h9ABC_DEF1, "R8");
    step(1, 0, 8'h10, 1, 0, "R7");
    step(1, 0, 8'h10, 0, 0, "R5");
    step(1, 0, 8'h10, 0, 0, "R5");
    // R9 inbox empty enable written by CPU (receiver), tag kept
    step(1, 1, 8'h10, 0, 32'h7000_1234, "R9");
    step(1, 1, 8'h10, 1, 32'h4000_0055, "R7");
    step(1, 1, 8'h10, 0, 32'h0000_0000, "R7");
    step(1, 0, 8'h10, 0, 0, "R5");
    // R6 outbox
    step(1, 1, 8'h20, 0, 32'hC000_0012, "R6");
    step(1, 0, 8'h20, 0, 0, "R7");
    step(1, 0, 8'h20, 1, 0, "R6");
    step(1, 0, 8'h20, 1, 0, "R8");
    step(1, 1, 8'h20, 1, 32'h8F00_00AA, "R9");
    step(1, 0, 8'h20, 0, 0, "R6");
    // R10 reserved offsets
    step(1, 0, 8'h0C, 0, 0, "R10");
    step(1, 0, 8'h14, 1, 0, "R10");
    step(1, 0, 8'h18, 0, 0, "R10");
    step(1, 0, 8'h1C, 1, 0, "R10");
    step(1, 0, 8'h3C, 0, 0, "R10");
    step(1, 1, 8'h14, 1, 32'hFFFF_FFFF, "R10");
    step(1, 1, 8'h1C, 0, 32'hFFFF_FFFF, "R10");
    step(1, 0, 8'h10, 1, 0, "R10");
    step(1, 0, 8'h20, 1, 0, "R10");
    step(1, 0, 8'h00, 1, 0, "R10");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule